// File: doc/BRIEF.md
# System Clock Source Selector

This controller picks which of three oscillators drives the system clock: an external primary oscillator, a low-frequency secondary oscillator, or an on-chip internal oscillator. Software writes a two-bit select field. The controller registers the new target and keeps the current source on the mux. It counts a fixed number of ticks from the target source and only then moves the mux select. A crystal-type primary source must also pass a start-up timer first. If the select field changes while a switch is pending, the pending switch is dropped and the new target is evaluated from zero.

The secondary oscillator runs whenever anything needs it. That can be any of four timer channels, the real-time clock configuration, the system clock select, or a software warm-up bit. The warm-up bit lets software start the oscillator early, so it is already stable when a peripheral asks for it. A two-bit mode input chooses the secondary driver strength, or releases its pins for general I/O. Two status flags report whether the primary or the secondary source is driving the clock. When both flags are clear, the internal oscillator is driving it.

Every interface is plain control and status. No data moves through the block, so there is no valid/ready handshake. The oscillator tick inputs are single-cycle strobes, synchronous to `clk`, one per cycle of the corresponding oscillator.

Top module: `clk_src_ctrl`

## Requirements
- R1: The select field decodes as follows: 00 means primary, 01 means secondary, 10 and 11 mean internal. On `clk_sel_o`, primary is 0, secondary is 1 and internal is 2. After reset, `clk_sel_o` is 2 and both running flags are 0.
- R2: `sec_en_o` is 1 whenever any of these is true: any `tmr_sec_req_i` bit is set, `rtc_sec_req_i` is set, `warm_req_i` is set, or the secondary source is the pending target or the current selection.
- R3: `warm_req_i` alone turns on `sec_en_o` and does not change `clk_sel_o`.
- R4: Primary modes 0, 1 and 2 on `pri_mode_i` are crystal modes. In these modes the primary source becomes usable only after START_TICKS primary ticks (default 1024) have been counted while the primary is enabled. Modes 3 to 7 are usable at once.
- R5: The start-up count restarts from zero each time `pri_en_o` drops, so each re-enable needs a full START_TICKS again.
- R6: A switch completes on the (SW_TICKS+1)-th rising edge after `sel_i` changes (default SW_TICKS=8), provided the target is ready and its tick is high on every cycle. Only cycles in which the target is ready and its tick is high count towards SW_TICKS. `clk_sel_o` holds its old value until the switch completes.
- R7: A change of `sel_i` while a switch is pending abandons that switch and restarts the count for the new target. This holds even in the cycle where the abandoned switch would have completed: the abandon takes priority.
- R8: `pri_run_o` is 1 only when `clk_sel_o` is primary and the primary start-up has finished. `sec_run_o` is 1 exactly when `clk_sel_o` is secondary. The two flags are never 1 together.
- R9: Secondary mode 11 sets `sec_hp_o`=`sec_en_o` and `sec_lp_o`=0. Mode 01 sets `sec_lp_o`=`sec_en_o` and `sec_hp_o`=0. Mode 10 turns both drivers off and sets `sec_pin_io_o`=1. Mode 00 turns both drivers off and sets `sec_pin_io_o`=0.
- R10: `pri_en_o` is 1 exactly while primary is the pending target or the current selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Software clock select field |
| pri_mode_i | input | 3 | Primary oscillator mode code |
| sec_cfg_i | input | 2 | Secondary oscillator mode code |
| tmr_sec_req_i | input | 4 | Per-timer requests for the secondary oscillator |
| rtc_sec_req_i | input | 1 | Real-time clock requests the secondary oscillator |
| warm_req_i | input | 1 | Software warm-up request |
| pri_tick_i | input | 1 | Primary oscillator cycle strobe |
| sec_tick_i | input | 1 | Secondary oscillator cycle strobe |
| int_tick_i | input | 1 | Internal oscillator cycle strobe |
| clk_sel_o | output | 2 | Glitch-free mux select (0 primary, 1 secondary, 2 internal) |
| pri_en_o | output | 1 | Primary oscillator enable |
| sec_en_o | output | 1 | Secondary oscillator enable |
| sec_hp_o | output | 1 | Secondary high-power driver on |
| sec_lp_o | output | 1 | Secondary low-power driver on |
| sec_pin_io_o | output | 1 | Secondary pins released for general I/O |
| pri_run_o | output | 1 | Primary is driving the system clock |
| sec_run_o | output | 1 | Secondary is driving the system clock |

## Verification
Two events can land on the same clock edge: the last counted tick of a pending switch, and a new write to the select field. The bench provokes this by starting a switch to the secondary source and rewriting `sel_i` to primary just before the eighth counting edge. It then checks that the mux stays on internal at that edge, and that the later switch to the crystal primary waits out the full start-up count. A scoreboard queue holds every mux change the bench expects. Any change on `clk_sel_o` that the queue does not hold is reported, and that is how the dropped switch is caught.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_t;

  function automatic src_t sel_decode(input logic [1:0] s);
    case (s)
      2'b00:   return SRC_PRI;
      2'b01:   return SRC_SEC;
      default: return SRC_INT;
    endcase
  endfunction

  function automatic logic mode_is_crystal(input logic [2:0] m);
    return (m <= 3'd2);
  endfunction

endpackage

// File: rtl/pri_startup_timer.sv
module pri_startup_timer #(
  parameter int START_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic crystal,
  output logic ready
);
  localparam int CW = $clog2(START_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(START_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!en)                   cnt_q <= '0;
    else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ready = en && (!crystal || cnt_q == LIMIT);

  // A fresh enable of a crystal source is never ready in its first cycle
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crystal && !$past(en)) |-> !ready);

endmodule

// File: rtl/sec_osc_request.sv
module sec_osc_request #(
  parameter int N_TMR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] tmr_req,
  input  logic             rtc_req,
  input  logic             warm_req,
  input  logic             sys_req,
  input  logic [1:0]       cfg,
  output logic             en,
  output logic             hp,
  output logic             lp,
  output logic             pins_io
);
  assign en      = (|tmr_req) | rtc_req | warm_req | sys_req;
  assign hp      = en && (cfg == 2'b11);
  assign lp      = en && (cfg == 2'b01);
  assign pins_io = (cfg == 2'b10);

  assert_warm_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warm_req |-> en);

  assert_one_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hp, lp, pins_io}));

endmodule

// File: rtl/switch_sequencer.sv
module switch_sequencer
  import clk_src_pkg::*;
#(
  parameter int SW_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  src_t       tgt,
  input  logic [2:0] rdy,
  input  logic [2:0] tick,
  output src_t       cur,
  output src_t       pend
);
  localparam int SW = (SW_TICKS < 1) ? 1 : SW_TICKS;
  localparam int CW = $clog2(SW + 1);
  localparam logic [CW-1:0] LAST = CW'(SW - 1);

  logic [CW-1:0] cnt_q;
  logic          go;

  always_comb begin
    case (pend)
      SRC_PRI: go = rdy[0] & tick[0];
      SRC_SEC: go = rdy[1] & tick[1];
      default: go = rdy[2] & tick[2];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= SRC_INT;
      pend  <= SRC_INT;
      cnt_q <= '0;
    end else if (tgt != pend) begin
      pend  <= tgt;
      cnt_q <= '0;
    end else if (pend != cur && go) begin
      if (cnt_q == LAST) begin
        cur   <= pend;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // A new select value always wins over a completing switch
  assert_abandon_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt != pend) |=> $stable(cur));

  // The mux only moves to the registered pending target
  assert_to_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur) |-> (cur == $past(pend)));

  assert_legal_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cur != 2'd3);

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int START_TICKS = 1024,
  parameter int SW_TICKS    = 8,
  parameter int N_TMR       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel_i,
  input  logic [2:0]       pri_mode_i,
  input  logic [1:0]       sec_cfg_i,
  input  logic [N_TMR-1:0] tmr_sec_req_i,
  input  logic             rtc_sec_req_i,
  input  logic             warm_req_i,
  input  logic             pri_tick_i,
  input  logic             sec_tick_i,
  input  logic             int_tick_i,
  output logic [1:0]       clk_sel_o,
  output logic             pri_en_o,
  output logic             sec_en_o,
  output logic             sec_hp_o,
  output logic             sec_lp_o,
  output logic             sec_pin_io_o,
  output logic             pri_run_o,
  output logic             sec_run_o
);
  src_t cur, pend, tgt;
  logic pri_rdy, sys_sec;

  assign tgt      = sel_decode(sel_i);
  assign pri_en_o = (pend == SRC_PRI) || (cur == SRC_PRI);
  assign sys_sec  = (pend == SRC_SEC) || (cur == SRC_SEC);

  pri_startup_timer #(.START_TICKS(START_TICKS)) u_ost (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (pri_en_o),
    .tick    (pri_tick_i),
    .crystal (mode_is_crystal(pri_mode_i)),
    .ready   (pri_rdy)
  );

  sec_osc_request #(.N_TMR(N_TMR)) u_sreq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_req  (tmr_sec_req_i),
    .rtc_req  (rtc_sec_req_i),
    .warm_req (warm_req_i),
    .sys_req  (sys_sec),
    .cfg      (sec_cfg_i),
    .en       (sec_en_o),
    .hp       (sec_hp_o),
    .lp       (sec_lp_o),
    .pins_io  (sec_pin_io_o)
  );

  switch_sequencer #(.SW_TICKS(SW_TICKS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .tgt   (tgt),
    .rdy   ({1'b1, sec_en_o, pri_rdy}),
    .tick  ({int_tick_i, sec_tick_i, pri_tick_i}),
    .cur   (cur),
    .pend  (pend)
  );

  assign clk_sel_o = cur;
  assign pri_run_o = (cur == SRC_PRI) && pri_rdy;
  assign sec_run_o = (cur == SRC_SEC);

  assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_run_o && sec_run_o));

  assert_sec_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_run_o |-> sec_en_o);

  assert_pri_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel_o == 2'd0) |-> pri_en_o);

endmodule

// File: tb/sim_clk_src_ctrl.sv
`timescale 1ns/1ps
module sim_clk_src_ctrl;
  import clk_src_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b10;
  logic [2:0] pmode = 3'd3;
  logic [1:0] scfg = 2'b11;
  logic [3:0] treq = '0;
  logic       rreq = 1'b0, wreq = 1'b0;
  logic       ptk = 1'b1, stk = 1'b1, itk = 1'b1;
  logic [1:0] csel;
  logic       pen, sen, shp, slp, sio, prun, srun;

  int n_chk = 0, n_err = 0;
  logic [1:0] expq[$];
  logic [1:0] last_sel = 2'd2;
  logic       done = 1'b0;

  always #2 clk = ~clk;

  clk_src_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .pri_mode_i(pmode), .sec_cfg_i(scfg),
    .tmr_sec_req_i(treq), .rtc_sec_req_i(rreq), .warm_req_i(wreq),
    .pri_tick_i(ptk), .sec_tick_i(stk), .int_tick_i(itk),
    .clk_sel_o(csel), .pri_en_o(pen), .sec_en_o(sen), .sec_hp_o(shp),
    .sec_lp_o(slp), .sec_pin_io_o(sio), .pri_run_o(prun), .sec_run_o(srun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: request a switch and record the mux change it must produce
  task automatic request(input logic [1:0] s, input logic [1:0] expect_src);
    sel = s;
    expq.push_back(expect_src);
  endtask

  // monitor: every mux change must match the next queued expectation
  always @(negedge clk) begin
    if (rst_n && !done && csel !== last_sel) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_err++;
        $display("FAIL R7: unexpected mux change actual=%0d expected=%0d", csel, last_sel);
      end else begin
        logic [1:0] e;
        e = expq.pop_front();
        if (csel !== e) begin
          n_err++;
          $display("FAIL R6: mux change actual=%0d expected=%0d", csel, e);
        end
      end
      last_sel = csel;
    end
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 reset sel", csel, 2);
    check("R8 reset pri_run", prun, 0);
    check("R8 reset sec_run", srun, 0);
    check("R2 reset sec_en", sen, 0);
    check("R10 reset pri_en", pen, 0);

    // R2 each requester alone
    for (int i = 0; i < 4; i++) begin
      treq = 4'b1 << i; #1;
      check("R2 timer req", sen, 1);
    end
    treq = '0; rreq = 1'b1; #1;
    check("R2 rtc req", sen, 1);
    // R9 driver modes with oscillator requested
    scfg = 2'b11; #1;
    check("R9 hp", {shp, slp, sio}, 3'b100);
    scfg = 2'b01; #1;
    check("R9 lp", {shp, slp, sio}, 3'b010);
    scfg = 2'b10; #1;
    check("R9 digital", {shp, slp, sio}, 3'b001);
    scfg = 2'b00; #1;
    check("R9 none", {shp, slp, sio}, 3'b000);
    scfg = 2'b11; rreq = 1'b0; #1;
    check("R2 no req", sen, 0);

    // R3 warm-up alone
    wreq = 1'b1;
    step(12);
    check("R3 warm en", sen, 1);
    check("R3 sel held", csel, 2);
    check("R3 sec_run", srun, 0);

    // R6 exact switch timing to secondary
    request(2'b01, 2'd1);
    step(8);
    check("R6 before last tick", csel, 2);
    step(1);
    check("R6 switched", csel, 1);
    check("R8 sec_run", srun, 1);
    wreq = 1'b0; #1;
    check("R2 selected keeps en", sen, 1);

    // R6 ticks gate the count
    itk = 1'b0;
    sel = 2'b10;
    step(20);
    check("R6 no ticks", csel, 1);
    expq.push_back(2'd2);
    itk = 1'b1;
    step(10);
    check("R6 ticks resume", csel, 2);

    // R4 immediate primary, R10 enable
    pmode = 3'd3;
    request(2'b00, 2'd0);
    step(9);
    check("R4 ext clock immediate", csel, 0);
    check("R8 pri_run", prun, 1);
    check("R10 pri_en", pen, 1);
    request(2'b10, 2'd2);
    step(10);
    check("R10 pri_en off", pen, 0);

    // R7 abandon coinciding with last tick
    pmode = 3'd2;
    sel = 2'b01;
    step(8);
    sel = 2'b00;
    step(1);
    check("R7 abandon wins", csel, 2);
    check("R10 pending pri_en", pen, 1);
    step(1000);
    check("R4 crystal waits", csel, 2);
    check("R8 pri_run waits", prun, 0);
    expq.push_back(2'd0);
    step(60);
    check("R4 crystal done", csel, 0);
    check("R8 pri_run done", prun, 1);

    // R5 restart of start-up after re-enable
    request(2'b10, 2'd2);
    step(10);
    check("R5 pri_en dropped", pen, 0);
    request(2'b00, 2'd0);
    step(1000);
    check("R5 full restart", csel, 2);
    step(60);
    check("R5 after restart", csel, 0);

    step(2);
    check("R6 queue drained", expq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule